// File: doc/BRIEF.md
# Load/Store Alignment Network

This block sits between a 64-bit register file and a memory that is eight bytes wide. It takes a memory access, described by its size, its lane offset (the low three address bits) and a load or store direction. For a load it picks the addressed bytes out of the memory word, moves them down to the least significant end of the register, and fills the upper bits with the sign bit or with zeros. For a store it moves the register bytes into the lanes they belong to and raises one write enable per written byte.

An access whose offset is not a multiple of its size is reported as misaligned. The block also reports that such an access would need two memory references. It does not carry out that split. A misaligned access produces no write enables and no load data.

The byte order is chosen by a parameter. In little-endian order lane 0 is the least significant byte of the value. In big-endian order lane 0 is the most significant byte. All results pass through one register stage, which a parameter can remove.

Top module: `mem_lane_aligner`

## Requirements
- R1: `misaligned` is 1 for a valid access exactly when offset mod size_bytes is not 0. Size is encoded as 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes, and the offset is `acc_offset` (address bits 2:0).
- R2: `two_access` equals `misaligned` for every access.
- R3: In little-endian order, an aligned load returns memory byte lane `offset+i` (bits 8k+7:8k for lane k) as result byte i, for i from 0 to size_bytes-1.
- R4: In big-endian order, lane k is memory bits 8(7-k)+7:8(7-k), and lane `offset` is the most significant byte of the value. A byte loaded from offset 4 is therefore memory byte 3, which is shifted right by 3 byte positions.
- R5: When `acc_unsigned`=0, a load narrower than 8 bytes fills the upper result bits with the top bit of the loaded value. When `acc_unsigned`=1, those bits are 0. A double-word load is never changed by extension.
- R6: An aligned store sets exactly size_bytes bits of `st_be`, where bit j enables memory bits 8j+7:8j. Those bits cover the lanes of the access. `st_data` holds the register bytes in those lanes, ordered as in R3/R4, and zero in every other lane.
- R7: A misaligned access drives `st_be`, `st_data` and `ld_data` to zero.
- R8: When `acc_valid`=0, all outputs are zero. A load never asserts `st_be`, and a store drives `ld_data` to zero.
- R9: With the output stage on, each result appears one clock after its inputs are sampled. While `rst` is high at a rising edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | Access size code (00/01/10/11 = 1/2/4/8 bytes) |
| acc_unsigned | input | 1 | 1 = zero-extend a load, 0 = sign-extend |
| acc_offset | input | 3 | Byte lane offset (address bits 2:0) |
| mem_rdata | input | 64 | Word read from memory |
| reg_wdata | input | 64 | Register value to store |
| ld_data | output | 64 | Aligned and extended load result |
| st_be | output | 8 | Per-lane write enables |
| st_data | output | 64 | Store data steered into lanes |
| misaligned | output | 1 | Access violates alignment |
| two_access | output | 1 | Access would need two memory references |

## Verification
Every result is due one rising edge after the inputs that produce it. The bench changes the inputs on a falling edge. On the next falling edge it compares all five outputs against a behavioural model that was evaluated when those inputs were applied. Two instances, one for each byte order, receive the same stimulus. That stimulus sweeps every size, offset and load/store mode, including all misaligned cases, and continues with random accesses. Reset is checked while a valid store is being presented.

// File: rtl/memalign_pkg.sv
package memalign_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } acc_size_e;

  function automatic int unsigned size_lanes(input logic [1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/mla_align_check.sv
module mla_align_check #(
  parameter int OFS_W = 3
) (
  input  logic [1:0]       size,
  input  logic [OFS_W-1:0] ofs,
  output logic             misal
);
  logic [OFS_W-1:0] low_mask;

  always_comb begin
    low_mask = OFS_W'(memalign_pkg::size_lanes(size) - 1);
    misal    = |(ofs & low_mask);
  end
endmodule

// File: rtl/mla_load_extract.sv
module mla_load_extract #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int SH_W   = 4
) (
  input  logic [LANES*LANE_W-1:0] word,
  input  logic [SH_W-1:0]         sh,
  input  logic [1:0]              size,
  input  logic                    uns,
  output logic [LANES*LANE_W-1:0] value
);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0] shifted;
  logic          fill;
  int unsigned   nl;

  always_comb begin
    shifted = word >> (LANE_W * int'(sh));
    nl      = memalign_pkg::size_lanes(size);
    fill    = uns ? 1'b0 : shifted[nl*LANE_W-1];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign value[k*LANE_W +: LANE_W] =
      ($unsigned(k) < nl) ? shifted[k*LANE_W +: LANE_W] : {LANE_W{fill}};
  end
endmodule

// File: rtl/mla_store_steer.sv
module mla_store_steer #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int SH_W   = 4
) (
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [SH_W-1:0]         sh,
  input  logic [1:0]              size,
  output logic [LANES-1:0]        be,
  output logic [LANES*LANE_W-1:0] data
);
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0]    moved;
  logic [LANES-1:0] lane_en;

  always_comb begin
    lane_en = LANES'(((32'd1 << memalign_pkg::size_lanes(size)) - 32'd1) << sh);
    moved   = wdata << (LANE_W * int'(sh));
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign data[k*LANE_W +: LANE_W] = lane_en[k] ? moved[k*LANE_W +: LANE_W] : '0;
  end

  assign be = lane_en;
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner #(
  parameter int LANES      = 8,
  parameter int LANE_W     = 8,
  parameter bit BIG_ENDIAN = 1'b0,
  parameter bit OUT_REG    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        acc_valid,
  input  logic                        acc_write,
  input  logic [1:0]                  acc_size,
  input  logic                        acc_unsigned,
  input  logic [$clog2(LANES)-1:0]    acc_offset,
  input  logic [LANES*LANE_W-1:0]     mem_rdata,
  input  logic [LANES*LANE_W-1:0]     reg_wdata,
  output logic [LANES*LANE_W-1:0]     ld_data,
  output logic [LANES-1:0]            st_be,
  output logic [LANES*LANE_W-1:0]     st_data,
  output logic                        misaligned,
  output logic                        two_access
);
  localparam int OFS_W = $clog2(LANES);
  localparam int SH_W  = OFS_W + 1;
  localparam int DW    = LANES * LANE_W;

  logic [SH_W-1:0]  nl;
  logic [SH_W-1:0]  sh;
  logic             misal_raw;
  logic [DW-1:0]    ld_raw, st_raw;
  logic [LANES-1:0] be_raw;

  logic             mis_n, two_n, ok_n;
  logic [DW-1:0]    ld_n, st_n;
  logic [LANES-1:0] be_n;

  assign nl = SH_W'(1) << acc_size;

  // Shift in lanes that brings the least significant value byte to lane 0.
  if (BIG_ENDIAN) begin : g_big
    assign sh = SH_W'(LANES) - SH_W'(acc_offset) - nl;
  end else begin : g_little
    assign sh = SH_W'(acc_offset);
  end

  mla_align_check #(.OFS_W(OFS_W)) u_check (
    .size (acc_size),
    .ofs  (acc_offset),
    .misal(misal_raw)
  );

  mla_load_extract #(.LANES(LANES), .LANE_W(LANE_W), .SH_W(SH_W)) u_load (
    .word (mem_rdata),
    .sh   (sh),
    .size (acc_size),
    .uns  (acc_unsigned),
    .value(ld_raw)
  );

  mla_store_steer #(.LANES(LANES), .LANE_W(LANE_W), .SH_W(SH_W)) u_store (
    .wdata(reg_wdata),
    .sh   (sh),
    .size (acc_size),
    .be   (be_raw),
    .data (st_raw)
  );

  always_comb begin
    mis_n = acc_valid & misal_raw;
    // Two-reference indication from the address arithmetic itself.
    two_n = acc_valid & ((SH_W'(acc_offset) % nl) != '0);
    ok_n  = acc_valid & ~misal_raw;
    ld_n  = (ok_n & ~acc_write) ? ld_raw : '0;
    be_n  = (ok_n &  acc_write) ? be_raw : '0;
    st_n  = (ok_n &  acc_write) ? st_raw : '0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        ld_data    <= '0;
        st_be      <= '0;
        st_data    <= '0;
        misaligned <= 1'b0;
        two_access <= 1'b0;
      end else begin
        ld_data    <= ld_n;
        st_be      <= be_n;
        st_data    <= st_n;
        misaligned <= mis_n;
        two_access <= two_n;
      end
    end

    // R6: enable count follows the size presented one cycle earlier
    p_be_width_r6: assert property (@(posedge clk) disable iff (rst)
      (st_be != '0) |-> ($countones(st_be) == (1 << $past(acc_size))));
  end else begin : g_comb
    assign ld_data    = ld_n;
    assign st_be      = be_n;
    assign st_data    = st_n;
    assign misaligned = mis_n;
    assign two_access = two_n;
  end

  // R7: a misaligned access leaves memory and register untouched
  p_quiet_misaligned_r7: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (st_be == '0 && st_data == '0 && ld_data == '0));

  // R2: two-reference flag agrees with the alignment flag
  p_two_access_r2: assert property (@(posedge clk) disable iff (rst)
    (two_access != misaligned) |-> 1'b0);

  // R6: the number of enabled lanes is a power of two
  p_be_pow2_r6: assert property (@(posedge clk) disable iff (rst)
    (st_be != '0) |-> (($countones(st_be) & ($countones(st_be) - 1)) == 0));

  // R8: a store never returns load data
  p_store_no_load_r8: assert property (@(posedge clk) disable iff (rst)
    (st_be != '0) |-> (ld_data == '0));
endmodule

// File: tb/mem_lane_aligner_test.sv
module mem_lane_aligner_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_unsigned = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [2:0]  acc_offset = 3'd0;
  logic [63:0] mem_rdata = '0, reg_wdata = '0;

  logic [63:0] ld_le, st_le, ld_be, st_be_d;
  logic [7:0]  be_le, be_be;
  logic        mis_le, two_le, mis_be, two_be;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [63:0] x_ld [2];
  logic [63:0] x_st [2];
  logic [7:0]  x_en [2];
  logic        x_mis[2];
  string       x_tag;
  bit          pending = 1'b0;

  always #10 clk = ~clk;

  mem_lane_aligner #(.BIG_ENDIAN(1'b0)) uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_unsigned(acc_unsigned), .acc_offset(acc_offset),
    .mem_rdata(mem_rdata), .reg_wdata(reg_wdata),
    .ld_data(ld_le), .st_be(be_le), .st_data(st_le),
    .misaligned(mis_le), .two_access(two_le));

  mem_lane_aligner #(.BIG_ENDIAN(1'b1)) uut_be (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_unsigned(acc_unsigned), .acc_offset(acc_offset),
    .mem_rdata(mem_rdata), .reg_wdata(reg_wdata),
    .ld_data(ld_be), .st_be(be_be), .st_data(st_be_d),
    .misaligned(mis_be), .two_access(two_be));

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: walk the bytes of the value one at a time.
  task automatic model(input int big, output logic [63:0] ld, output logic [7:0] en,
                       output logic [63:0] st, output logic mis);
    int n = 1 << acc_size;
    ld = '0; en = '0; st = '0;
    mis = acc_valid && ((acc_offset % n) != 0);
    if (acc_valid && !mis) begin
      for (int i = 0; i < n; i++) begin
        int lane = big ? (acc_offset + n - 1 - i) : (acc_offset + i);
        int phys = big ? (7 - lane) : lane;
        if (acc_write) begin
          en[phys] = 1'b1;
          st[8*phys +: 8] = reg_wdata[8*i +: 8];
        end else begin
          ld[8*i +: 8] = mem_rdata[8*phys +: 8];
        end
      end
      if (!acc_write && !acc_unsigned && n < 8)
        for (int i = n; i < 8; i++) ld[8*i +: 8] = {8{ld[8*n-1]}};
    end
  endtask

  task automatic compare();
    check("R1", "misaligned le", 64'(mis_le), 64'(x_mis[0]));
    check("R1", "misaligned be", 64'(mis_be), 64'(x_mis[1]));
    check("R2", "two_access le", 64'(two_le), 64'(x_mis[0]));
    check("R2", "two_access be", 64'(two_be), 64'(x_mis[1]));
    check(x_tag, "ld_data le", ld_le, x_ld[0]);
    check(x_tag == "R3" ? "R4" : x_tag, "ld_data be", ld_be, x_ld[1]);
    check(x_tag, "st_be le", 64'(be_le), 64'(x_en[0]));
    check(x_tag, "st_be be", 64'(be_be), 64'(x_en[1]));
    check(x_tag, "st_data le", st_le, x_st[0]);
    check(x_tag, "st_data be", st_be_d, x_st[1]);
  endtask

  // One access: compare the previous result, then apply and model the new one.
  task automatic step(input bit v, input bit w, input logic [1:0] sz, input bit u,
                      input logic [2:0] ofs, input logic [63:0] rd, input logic [63:0] wd);
    @(negedge clk);
    if (pending) compare();
    acc_valid = v; acc_write = w; acc_size = sz; acc_unsigned = u;
    acc_offset = ofs; mem_rdata = rd; reg_wdata = wd;
    model(0, x_ld[0], x_en[0], x_st[0], x_mis[0]);
    model(1, x_ld[1], x_en[1], x_st[1], x_mis[1]);
    if (!v) x_tag = "R8";
    else if (x_mis[0]) x_tag = "R7";
    else if (w) x_tag = "R6";
    else if (!u && sz != 2'b11) x_tag = "R5";
    else x_tag = "R3";
    pending = 1'b1;
  endtask

  initial begin
    // R9: outputs held at zero under reset even with a valid store presented
    acc_valid = 1'b1; acc_write = 1'b1; acc_size = 2'b11;
    reg_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9", "reset ld_data le", ld_le, '0);
    check("R9", "reset st_be le", 64'(be_le), '0);
    check("R9", "reset st_data be", st_be_d, '0);
    check("R9", "reset misaligned be", 64'(mis_be), '0);
    @(negedge clk);
    rst = 1'b0;

    // R4: byte at offset 4, big-endian, comes from memory byte 3
    step(1, 0, 2'b00, 1, 3'd4, 64'h1122_3344_5566_7788, '0);
    @(negedge clk);
    compare();
    pending = 1'b0;
    check("R4", "be byte offset 4", ld_be, 64'h0000_0000_0000_0055);
    check("R3", "le byte offset 4", ld_le, 64'h0000_0000_0000_0044);

    // Exhaustive sweep of size, offset and mode, two data patterns.
    for (int pat = 0; pat < 2; pat++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int o = 0; o < 8; o++) begin
          for (int m = 0; m < 3; m++) begin
            step(1, m == 2, 2'(sz), m == 1, 3'(o),
                 pat == 0 ? 64'hF1E2_D3C4_B5A6_9788 : 64'h0172_6354_4536_2718,
                 pat == 0 ? 64'h8877_6655_4433_2211 : 64'hFEDC_BA98_7654_3210);
          end
        end
      end
    end

    // R8: idle cycles with busy inputs
    step(0, 1, 2'b11, 0, 3'd0, '1, '1);
    step(0, 0, 2'b01, 0, 3'd3, '1, '1);

    // Random accesses
    for (int k = 0; k < 400; k++) begin
      step($urandom_range(0, 7) != 0, 1'($urandom), 2'($urandom), 1'($urandom),
           3'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end

    @(negedge clk);
    compare();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule